// File: doc/BRIEF.md
# Multiplexed-Bus Memory Target

This block is a target for a 32-bit parallel bus on which address and data share one set of lines. It runs on a single clock. At the start of a transaction it captures the address and the command. If the access is a memory read or write that falls inside its fixed, power-of-two-sized window, it claims the transaction. It then completes a linear burst against a small internal word array.

The handshake lines are active low. A data phase completes only in a clock where both the initiator ready line and the target ready line are low. The lines that tell the two phases apart double as byte enables during data phases. When a burst would run past the top word of the window, the target asks the initiator to stop.

Every line that the target can drive is brought out as a drive value plus an output enable. The pads themselves sit outside the block. Before an enable is removed, each shared control line is driven to its inactive level for one clock. Parity over the address/data and command/enable lines follows one clock after the values it covers.

Top module: `bus_target`

## Requirements
- R1: The address and command are taken only on a clock edge at which `frame_n` is low and, in the previous clock, both `frame_n` and `irdy_n` were high. A low `frame_n` that follows a clock with `irdy_n` low starts nothing.
- R2: An access is claimed only if all of the following hold: address bits 31:6 equal those of `0x8000_0000`, address bits 1:0 are `00`, and the command on `cbe_n` is `0110` (memory read) or `0111` (memory write). When it is claimed, `devsel_n_out` is low with `devsel_oe` high from the next clock. When it is not claimed, every output enable stays low and the word array is unchanged.
- R3: On a claimed write, `trdy_n_out` is low from the first clock after the address phase. A completed phase stores byte i (bits 8i+7..8i) only when `cbe_n[i]` is 0.
- R4: On a claimed read, the first clock after the address phase is a turnaround: `ad_oe` is 0, `trdy_n_out` is high and `devsel_n_out` is low. From the next clock, `ad_oe` is 1, `trdy_n_out` is low and `ad_out` holds the word at the current index.
- R5: A clock with `irdy_n` high completes no phase. The index holds, nothing is written, and read data on `ad_out` stays the same.
- R6: The first index is address bits 5:2. Each completed phase advances the index by one word.
- R7: A phase that completes with `frame_n` high ends the transaction. In the next clock, `devsel_n_out`, `trdy_n_out` and `stop_n_out` are driven high with their enables set and `ad_oe` is 0. In the clock after that, all enables are 0.
- R8: While the index is at word 15, `stop_n_out` is low together with `trdy_n_out`. If that phase completes with `frame_n` still low, the target keeps `trdy_n_out` high and `stop_n_out` and `devsel_n_out` low, writes nothing, and keeps `ad_oe` set on reads. It does this until `frame_n` is high, then ends as in R7.
- R9: `par_out` equals the XOR of the previous clock's `ad_out` and `cbe_n`, and `par_oe` equals the previous clock's `ad_oe`.
- R10: During and after reset, all output enables are 0 and `devsel_n_out`, `trdy_n_out` and `stop_n_out` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Transaction-in-progress line from the initiator |
| irdy_n | input | 1 | Initiator ready |
| ad_in | input | 32 | Address/data lines as seen at the pads |
| cbe_n | input | 4 | Command in address phase, active-low byte enables in data phases |
| ad_out | output | 32 | Read data drive value |
| ad_oe | output | 1 | Enable for `ad_out` |
| par_out | output | 1 | Even parity drive value |
| par_oe | output | 1 | Enable for `par_out` |
| trdy_n_out | output | 1 | Target ready drive value |
| trdy_oe | output | 1 | Enable for `trdy_n_out` |
| devsel_n_out | output | 1 | Claim indication drive value |
| devsel_oe | output | 1 | Enable for `devsel_n_out` |
| stop_n_out | output | 1 | Stop request drive value |
| stop_oe | output | 1 | Enable for `stop_n_out` |

## Verification
A data transfer and a stop request can fall in the same clock. In the phase that addresses word 15, the target shows ready and stop together. If that phase completes while the initiator still holds `frame_n` low, the hold state of R8 follows. The bench provokes this with a write burst and a read burst that both begin at the top of the window. It checks the data stored or returned for word 15, checks that word 0 stays unchanged after the wrap, and checks that reads keep driving `ad_out` through the hold clocks.

// File: rtl/bus_tgt_pkg.sv
package bus_tgt_pkg;

  localparam int BUS_W  = 32;
  localparam int LANES  = BUS_W / 8;

  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN,
    ST_DATA,
    ST_HOLD,
    ST_RELEASE
  } tgt_state_e;

  // Even parity bit: makes the total count of ones across data, enables and bit even.
  function automatic logic even_par(input logic [BUS_W-1:0] d, input logic [LANES-1:0] c);
    return ^{d, c};
  endfunction

  // Replace only the byte lanes whose active-low enable is 0.
  function automatic logic [BUS_W-1:0] merge_lanes(input logic [BUS_W-1:0] old_word,
                                                   input logic [BUS_W-1:0] new_word,
                                                   input logic [LANES-1:0] lane_n);
    logic [BUS_W-1:0] r;
    r = old_word;
    for (int b = 0; b < LANES; b++) begin
      if (!lane_n[b]) r[8*b +: 8] = new_word[8*b +: 8];
    end
    return r;
  endfunction

endpackage

// File: rtl/bus_tgt_decode.sv
module bus_tgt_decode
  import bus_tgt_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR = 32'h8000_0000,
  parameter int          IDX_W     = 4
) (
  input  logic [BUS_W-1:0] addr,
  input  logic [3:0]       cmd,
  output logic             hit,
  output logic             is_rd,
  output logic             is_wr,
  output logic [IDX_W-1:0] first_idx
);

  localparam int TAG_LSB = IDX_W + 2;

  logic tag_match;
  logic aligned;

  assign tag_match = (addr[BUS_W-1:TAG_LSB] == BASE_ADDR[BUS_W-1:TAG_LSB]);
  assign aligned   = (addr[1:0] == 2'b00);
  assign is_rd     = (cmd == CMD_MEM_RD);
  assign is_wr     = (cmd == CMD_MEM_WR);
  assign hit       = tag_match && aligned && (is_rd || is_wr);
  assign first_idx = addr[TAG_LSB-1:2];

endmodule

// File: rtl/bus_tgt_regs.sv
module bus_tgt_regs
  import bus_tgt_pkg::*;
#(
  parameter int WORDS = 16,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [BUS_W-1:0] wdata,
  input  logic [LANES-1:0] lane_n,
  output logic [BUS_W-1:0] rdata
);

  logic [BUS_W-1:0] mem [WORDS];
  logic [WORDS-1:0] word_we;

  for (genvar w = 0; w < WORDS; w++) begin : g_sel
    assign word_we[w] = we && (idx == IDX_W'(w));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < WORDS; w++) mem[w] <= '0;
    end else begin
      for (int w = 0; w < WORDS; w++) begin
        if (word_we[w]) mem[w] <= merge_lanes(mem[w], wdata, lane_n);
      end
    end
  end

  assign rdata = mem[idx];

  assert_single_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(word_we));

endmodule

// File: rtl/bus_tgt_parity.sv
module bus_tgt_parity
  import bus_tgt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BUS_W-1:0] ad,
  input  logic [LANES-1:0] cbe_n,
  input  logic             ad_driven,
  output logic             par,
  output logic             par_en
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par    <= 1'b0;
      par_en <= 1'b0;
    end else begin
      par    <= even_par(ad, cbe_n);
      par_en <= ad_driven;
    end
  end

endmodule

// File: rtl/bus_target.sv
module bus_target
  import bus_tgt_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR = 32'h8000_0000,
  parameter int          WORDS     = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_n,
  input  logic        irdy_n,
  input  logic [31:0] ad_in,
  input  logic [3:0]  cbe_n,
  output logic [31:0] ad_out,
  output logic        ad_oe,
  output logic        par_out,
  output logic        par_oe,
  output logic        trdy_n_out,
  output logic        trdy_oe,
  output logic        devsel_n_out,
  output logic        devsel_oe,
  output logic        stop_n_out,
  output logic        stop_oe
);

  localparam int IDX_W = $clog2(WORDS);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(WORDS - 1);

  tgt_state_e       state, state_nx;
  logic [IDX_W-1:0] idx;
  logic             rd_q;
  logic             frame_q, irdy_q;

  // Named events for the assertions and the datapath.
  logic             addr_phase;
  logic             start;
  logic             hit, is_rd, is_wr;
  logic [IDX_W-1:0] first_idx;
  logic             trdy_act;
  logic             xfer_done;
  logic             at_top;
  logic             claimed;
  logic             wr_en;
  logic [31:0]      rdata;

  bus_tgt_decode #(.BASE_ADDR(BASE_ADDR), .IDX_W(IDX_W)) u_decode (
    .addr      (ad_in),
    .cmd       (cbe_n),
    .hit       (hit),
    .is_rd     (is_rd),
    .is_wr     (is_wr),
    .first_idx (first_idx)
  );

  // Bus-idle history: both lines high in the previous clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= 1'b1;
      irdy_q  <= 1'b1;
    end else begin
      frame_q <= frame_n;
      irdy_q  <= irdy_n;
    end
  end

  assign addr_phase = !frame_n && frame_q && irdy_q;
  assign start      = (state == ST_IDLE) && addr_phase;
  assign trdy_act   = (state == ST_DATA);
  assign xfer_done  = trdy_act && !irdy_n;
  assign at_top     = (idx == TOP_IDX);
  assign claimed    = (state == ST_TURN) || (state == ST_DATA) || (state == ST_HOLD);
  assign wr_en      = xfer_done && !rd_q;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:    if (start && hit) state_nx = is_rd ? ST_TURN : ST_DATA;
      ST_TURN:    state_nx = ST_DATA;
      ST_DATA: begin
        if (xfer_done) begin
          if (frame_n)     state_nx = ST_RELEASE;
          else if (at_top) state_nx = ST_HOLD;
        end
      end
      ST_HOLD:    if (frame_n) state_nx = ST_RELEASE;
      ST_RELEASE: state_nx = ST_IDLE;
      default:    state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      idx   <= '0;
      rd_q  <= 1'b0;
    end else begin
      state <= state_nx;
      if (start && hit) begin
        idx  <= first_idx;
        rd_q <= is_rd;
      end else if (xfer_done) begin
        idx  <= idx + 1'b1;
      end
    end
  end

  bus_tgt_regs #(.WORDS(WORDS)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (wr_en),
    .idx    (idx),
    .wdata  (ad_in),
    .lane_n (cbe_n),
    .rdata  (rdata)
  );

  // Drive values and enables follow the registered state only.
  always_comb begin
    devsel_oe    = claimed || (state == ST_RELEASE);
    trdy_oe      = devsel_oe;
    stop_oe      = devsel_oe;
    devsel_n_out = !claimed;
    trdy_n_out   = !trdy_act;
    stop_n_out   = !((trdy_act && at_top) || (state == ST_HOLD));
    ad_oe        = rd_q && ((state == ST_DATA) || (state == ST_HOLD));
    ad_out       = rdata;
  end

  bus_tgt_parity u_parity (
    .clk       (clk),
    .rst_n     (rst_n),
    .ad        (ad_out),
    .cbe_n     (cbe_n),
    .ad_driven (ad_oe),
    .par       (par_out),
    .par_en    (par_oe)
  );

  assert_no_late_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !(frame_q && irdy_q)) |=> !devsel_oe);

  assert_claim_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && hit) |=> (devsel_oe && !devsel_n_out));

  assert_ignore_miss_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !hit) |=> (!devsel_oe && !trdy_oe && !stop_oe && !ad_oe));

  assert_write_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && hit && is_wr) |=> !trdy_n_out);

  assert_turnaround_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && hit && is_rd) |=> (!ad_oe && trdy_n_out));

  assert_wait_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (trdy_act && irdy_n) |=> $stable(idx));

  assert_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> (idx == IDX_W'($past(idx) + 1'b1)));

  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RELEASE) |-> (devsel_oe && trdy_oe && stop_oe && devsel_n_out
                               && trdy_n_out && stop_n_out && !ad_oe));

  assert_release_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RELEASE) |=> (!devsel_oe && !trdy_oe && !stop_oe));

  assert_stop_claimed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_n_out |-> (stop_oe && !devsel_n_out));

  assert_hold_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD && rd_q) |-> (ad_oe && trdy_n_out));

  assert_par_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |=> par_oe);

endmodule

// File: tb/bus_target_tb.sv
module bus_target_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] RD = 4'b0110;
  localparam logic [3:0] WR = 4'b0111;

  typedef struct packed {
    logic        wr;
    logic [31:0] addr;
    logic [3:0]  len;
    logic [3:0]  lane_n;
    logic [3:0]  wait_at;
    logic [31:0] seed;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 32'h8000_0000, 4'd4, 4'b0000, 4'd15, 32'h1122_3344},
    '{1'b1, 32'h8000_0010, 4'd3, 4'b1010, 4'd1,  32'hA5A5_0F0F},
    '{1'b0, 32'h8000_0000, 4'd4, 4'b0000, 4'd2,  32'h0},
    '{1'b0, 32'h8000_0010, 4'd3, 4'b0000, 4'd15, 32'h0},
    '{1'b1, 32'h8000_0020, 4'd1, 4'b0110, 4'd15, 32'hCAFE_F00D},
    '{1'b0, 32'h8000_0020, 4'd2, 4'b0000, 4'd0,  32'h0},
    '{1'b1, 32'h8000_0030, 4'd3, 4'b1111, 4'd0,  32'h7777_7777},
    '{1'b0, 32'h8000_0030, 4'd3, 4'b0000, 4'd15, 32'h0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_n, irdy_n;
  logic [31:0] ad_in;
  logic [3:0] cbe_n;
  logic [31:0] ad_out;
  logic ad_oe, par_out, par_oe, trdy_n_out, trdy_oe, devsel_n_out, devsel_oe, stop_n_out, stop_oe;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;
  logic [31:0] model [16];
  logic exp_par, exp_par_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_target u_dut (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n), .ad_in(ad_in), .cbe_n(cbe_n),
    .ad_out(ad_out), .ad_oe(ad_oe), .par_out(par_out), .par_oe(par_oe),
    .trdy_n_out(trdy_n_out), .trdy_oe(trdy_oe), .devsel_n_out(devsel_n_out),
    .devsel_oe(devsel_oe), .stop_n_out(stop_n_out), .stop_oe(stop_oe)
  );

  // Parity expectation built from port values seen just before each edge.
  always @(posedge clk) begin
    exp_par    <= ^{ad_out, cbe_n};
    exp_par_oe <= ad_oe;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_par(input string tag);
    check(par_oe == exp_par_oe, {tag, " R9 par_oe"}, {31'd0, par_oe}, {31'd0, exp_par_oe});
    if (exp_par_oe)
      check(par_out == exp_par, {tag, " R9 par value"}, {31'd0, par_out}, {31'd0, exp_par});
  endtask

  task automatic go_idle();
    frame_n = 1'b1; irdy_n = 1'b1; ad_in = '0; cbe_n = 4'hF;
  endtask

  task automatic check_off(input string tag);
    check(!devsel_oe && !trdy_oe && !stop_oe && !ad_oe, tag,
          {28'd0, devsel_oe, trdy_oe, stop_oe, ad_oe}, 32'd0);
  endtask

  task automatic check_release(input string tag);
    check(devsel_oe && trdy_oe && stop_oe && devsel_n_out && trdy_n_out && stop_n_out && !ad_oe,
          tag, {25'd0, devsel_oe, trdy_oe, stop_oe, devsel_n_out, trdy_n_out, stop_n_out, ad_oe},
          32'h7E);
  endtask

  task automatic write_burst(input logic [31:0] a, input logic [3:0] cmd, input int len,
                             input logic [3:0] lane_n, input int wait_at,
                             input logic [31:0] seed, input bit claimed);
    logic [3:0] base_i;
    logic [31:0] d;
    base_i = a[5:2];
    @(negedge clk); frame_n = 1'b0; irdy_n = 1'b1; ad_in = a; cbe_n = cmd;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      if (claimed)
        check(devsel_oe && !devsel_n_out && !trdy_n_out, "R3 write ready",
              {29'd0, devsel_oe, devsel_n_out, trdy_n_out}, 32'h4);
      else
        check_off("R2 ignored access");
      if (k == wait_at) begin
        frame_n = 1'b0; irdy_n = 1'b1; ad_in = 32'hDEAD_BEEF; cbe_n = 4'h0;
        @(negedge clk);
        if (claimed) check(!trdy_n_out && devsel_oe, "R5 write wait", {31'd0, trdy_n_out}, 32'd0);
      end
      d = seed + k * 32'h0101_0101;
      ad_in = d; cbe_n = lane_n; irdy_n = 1'b0; frame_n = (k == len - 1);
      if (claimed)
        for (int b = 0; b < 4; b++)
          if (!lane_n[b]) model[4'(base_i + k)][8*b +: 8] = d[8*b +: 8];
    end
    @(negedge clk);
    if (claimed) check_release("R7 write release");
    else check_off("R2 ignored tail");
    go_idle();
    @(negedge clk);
    check_off("R7 enables off");
  endtask

  task automatic read_burst(input logic [31:0] a, input int len, input int wait_at);
    logic [31:0] e;
    @(negedge clk); frame_n = 1'b0; irdy_n = 1'b1; ad_in = a; cbe_n = RD;
    @(negedge clk);
    check(devsel_oe && !devsel_n_out && trdy_n_out && !ad_oe, "R4 turnaround",
          {28'd0, devsel_oe, devsel_n_out, trdy_n_out, ad_oe}, 32'hA);
    irdy_n = 1'b0; frame_n = (len == 1); cbe_n = 4'h0; ad_in = '0;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      e = model[4'(a[5:2] + k)];
      check(ad_oe && !trdy_n_out, "R4 read drive", {30'd0, ad_oe, trdy_n_out}, 32'h2);
      check(ad_out == e, "R6 read data", ad_out, e);
      check_par("read");
      if (k == wait_at) begin
        irdy_n = 1'b1; frame_n = 1'b0; cbe_n = 4'h5;
        @(negedge clk);
        check(ad_oe && ad_out == e, "R5 read wait", ad_out, e);
        check_par("wait");
        cbe_n = 4'h0;
      end
      irdy_n = 1'b0; frame_n = (k == len - 1);
    end
    @(negedge clk);
    check_release("R7 read release");
    check_par("release");
    go_idle();
    @(negedge clk);
    check_off("R7 enables off");
    check_par("after");
  endtask

  initial begin
    go_idle();
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_off("R10 reset enables");
    check(devsel_n_out && trdy_n_out && stop_n_out, "R10 reset levels",
          {29'd0, devsel_n_out, trdy_n_out, stop_n_out}, 32'h7);
    rst_n = 1'b1;
    @(negedge clk);
    check_off("R10 after reset");

    for (int v = 0; v < NV; v++) begin
      if (VECS[v].wr)
        write_burst(VECS[v].addr, WR, int'(VECS[v].len), VECS[v].lane_n,
                    int'(VECS[v].wait_at), VECS[v].seed, 1'b1);
      else
        read_burst(VECS[v].addr, int'(VECS[v].len), int'(VECS[v].wait_at));
    end

    // R2: outside window, misaligned, and wrong command are all ignored.
    write_burst(32'h9000_0000, WR, 2, 4'h0, 15, 32'hBAD0_0001, 1'b0);
    write_burst(32'h8000_0002, WR, 1, 4'h0, 15, 32'hBAD0_0002, 1'b0);
    write_burst(32'h8000_0000, 4'b0011, 1, 4'h0, 15, 32'hBAD0_0003, 1'b0);
    read_burst(32'h8000_0000, 1, 15);

    // R1: frame low right after a clock with irdy low is not an address phase.
    @(negedge clk); frame_n = 1'b1; irdy_n = 1'b0;
    @(negedge clk); frame_n = 1'b0; irdy_n = 1'b1; ad_in = 32'h8000_0004; cbe_n = WR;
    @(negedge clk);
    check_off("R1 no start off idle");
    irdy_n = 1'b0; ad_in = 32'hFFFF_FFFF; cbe_n = 4'h0;
    @(negedge clk);
    check_off("R1 no late claim");
    frame_n = 1'b1;
    @(negedge clk); go_idle();
    @(negedge clk);
    read_burst(32'h8000_0004, 1, 15);

    // R8: write burst reaching the top word.
    @(negedge clk); frame_n = 1'b0; irdy_n = 1'b1; ad_in = 32'h8000_0038; cbe_n = WR;
    @(negedge clk);
    check(stop_n_out, "R8 no stop below top", {31'd0, stop_n_out}, 32'd1);
    ad_in = 32'h1414_1414; cbe_n = 4'h0; irdy_n = 1'b0; frame_n = 1'b0;
    model[14] = 32'h1414_1414;
    @(negedge clk);
    check(!stop_n_out && !trdy_n_out && !devsel_n_out, "R8 stop with ready",
          {29'd0, stop_n_out, trdy_n_out, devsel_n_out}, 32'd0);
    ad_in = 32'h1515_1515;
    model[15] = 32'h1515_1515;
    @(negedge clk);
    check(trdy_n_out && !stop_n_out && !devsel_n_out, "R8 hold",
          {29'd0, trdy_n_out, stop_n_out, devsel_n_out}, 32'h4);
    ad_in = 32'hEEEE_EEEE;
    @(negedge clk);
    check(trdy_n_out && !stop_n_out, "R8 hold persists", {30'd0, trdy_n_out, stop_n_out}, 32'h2);
    frame_n = 1'b1;
    @(negedge clk);
    check_release("R8 release after hold");
    go_idle();
    @(negedge clk);
    check_off("R8 enables off");
    read_burst(32'h8000_0038, 2, 15);
    read_burst(32'h8000_0000, 1, 15);

    // R8: read at the top word keeps driving during the hold.
    @(negedge clk); frame_n = 1'b0; irdy_n = 1'b1; ad_in = 32'h8000_003C; cbe_n = RD;
    @(negedge clk);
    irdy_n = 1'b0; frame_n = 1'b0; cbe_n = 4'h0; ad_in = '0;
    @(negedge clk);
    check(ad_out == model[15] && !stop_n_out, "R8 read top word", ad_out, model[15]);
    @(negedge clk);
    check(ad_oe && trdy_n_out && !stop_n_out, "R8 read hold drives",
          {29'd0, ad_oe, trdy_n_out, stop_n_out}, 32'h6);
    frame_n = 1'b1;
    @(negedge clk);
    check_release("R8 read release");
    go_idle();
    @(negedge clk);
    check_off("R8 read enables off");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

endmodule